// File: doc/BRIEF.md
# I2C Master Start-Condition Sequencer

This block is the control core on the master side of an I2C controller. Software asks for a Start with a one-cycle request. The block waits until the bus is free and drives a Start on the open-drain SCL and SDA lines. It then marks itself as master and raises a start-sent flag, which can also drive an event interrupt. The address byte reaches the block only after software has read the status and then written the byte into the data port. The block then shifts the byte out MSB first and samples the slave's acknowledge on the ninth clock. After that it holds SCL low until software asks for a repeated Start or a Stop.

The input clock frequency is given in MHz. The block checks it against a minimum of 2 MHz in standard mode and 4 MHz in fast mode, and it will not start a transfer while the setting is below that minimum. A programmable half-period count sets how many input-clock cycles each SCL high phase and each SCL low phase lasts. Software picks this count so that the clock runs at 100 kHz or 400 kHz. The address byte arrives on a valid/ready port. The source holds `dr_data` steady while `dr_valid` is high and `dr_ready` is low. The block takes the byte on the cycle where both are high. `dr_ready` rises only after a status read (`sr1_rd`) made while the start-sent flag is set, so a write that comes without that read is held back.

Top module: `i2c_start_seq`

## Requirements
- R1: While reset is held and right after it, both lines are released (`scl_oe`=0, `sda_oe`=0) and `sb`, `master` and `busy` are 0.
- R2: If a START request arrives while `busy` is 1, no line is driven and `master` stays 0. The Start is issued only after `busy` returns to 0, and `master` is then set.
- R3: `busy` goes to 1 when SDA falls while SCL is high, and it goes back to 0 when SDA rises while SCL is high.
- R4: A Start pulls SDA low while SCL is high for `half_period` cycles. It then pulls SCL low for `half_period` cycles, after which `sb` is set while `master` is 1.
- R5: Only one sequence clears `sb`: an `sr1_rd` pulse while `sb` is 1, followed by a `dr_valid`/`dr_ready` handshake. `dr_ready` stays 0 until that read has happened, and a read made while `sb` is 0 does not count toward a later `sb`.
- R6: `evt_irq` is 1 exactly when `sb` and `evt_ie` are both 1.
- R7: The accepted byte goes out MSB first, one bit per SCL pulse. On the ninth pulse SDA is released and the acknowledge is sampled: `ack_ok`=1 when the slave holds SDA low, 0 when it does not. SCL is then held low with SDA released until the next command.
- R8: A START request made while `master` is 1 does not disturb the byte in progress. After the ninth clock the block releases SDA, then releases SCL, and then issues a Start on the same timing as R4.
- R9: A STOP request made while `master` is 1 takes effect after the current byte. SDA is pulled low with SCL low, SCL is released, and then SDA is released. `master` then clears. If a START is also pending, the START is served first. A STOP request while `master` is 0 is ignored.
- R10: `cfg_bad`=1 when `freq_mhz` is below 2 with `fast_mode`=0, or below 4 with `fast_mode`=1. A START request made while `cfg_bad`=1 or `periph_en`=0 is ignored.
- R11: During the address byte, every SCL high phase and every SCL low phase lasts exactly `half_period` input-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| periph_en | input | 1 | Peripheral enable |
| fast_mode | input | 1 | 1 selects 400 kHz mode for the frequency check |
| freq_mhz | input | FREQ_W | Input clock frequency in MHz |
| half_period | input | DIV_W | Input-clock cycles per SCL high or low phase |
| start_req | input | 1 | One-cycle request for a Start or repeated Start |
| stop_req | input | 1 | One-cycle request for a Stop after the current byte |
| evt_ie | input | 1 | Event interrupt enable |
| sr1_rd | input | 1 | Status-register read strobe |
| dr_valid | input | 1 | Address byte valid |
| dr_ready | output | 1 | Block accepts the address byte |
| dr_data | input | BYTE_W | Address byte (7-bit address and direction bit) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Bus busy flag |
| master | output | 1 | 1 while the block owns the bus |
| sb | output | 1 | Start-sent flag |
| evt_irq | output | 1 | Event interrupt |
| ack_ok | output | 1 | Address acknowledged by a slave |
| cfg_bad | output | 1 | Clock frequency setting below the minimum |

## Verification
The properties assume that `half_period` is at least 2, exceeds the synchronizer depth, and stays constant while `master` is 1. They also assume that the lines follow a wired-AND of every driver, with no clock stretching and no second master once this block has begun its Start. The bench respects all of these. It uses a half-period of 4 and drives the external master only before the block's own Start. Its slave drives SDA only during the acknowledge clock, and it changes inputs only on the falling clock edge, holding `dr_data` steady while `dr_valid` waits for `dr_ready`.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

  typedef enum logic [3:0] {
    MS_IDLE,
    MS_ST_SDA,
    MS_ST_SCL,
    MS_HOLD,
    MS_BIT_LO,
    MS_BIT_HI,
    MS_BYTE_END,
    MS_RS_SDA,
    MS_RS_SCL,
    MS_SP_SDA,
    MS_SP_SCL,
    MS_SP_REL
  } ms_state_e;

endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic busy
);

  logic [SYNC_STAGES-1:0] scl_q;
  logic [SYNC_STAGES-1:0] sda_q;
  logic                   scl_p;
  logic                   sda_p;
  logic                   scl_now;
  logic                   start_det;
  logic                   stop_det;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[0] <= 1'b1;
          sda_q[0] <= 1'b1;
        end else begin
          scl_q[0] <= scl_i;
          sda_q[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[g] <= 1'b1;
          sda_q[g] <= 1'b1;
        end else begin
          scl_q[g] <= scl_q[g-1];
          sda_q[g] <= sda_q[g-1];
        end
      end
    end
  end

  assign scl_now = scl_q[SYNC_STAGES-1];
  assign sda_s   = sda_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_now;
      sda_p <= sda_s;
    end
  end

  // SDA edge while SCL stays high marks a bus condition
  assign start_det = scl_now && scl_p && sda_p && !sda_s;
  assign stop_det  = scl_now && scl_p && !sda_p && sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy <= 1'b0;
    else if (start_det) busy <= 1'b1;
    else if (stop_det)  busy <= 1'b0;
  end

endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] period,
  output logic             done
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] load;

  assign load = (period == '0) ? '0 : period - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (restart)       cnt_q <= load;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/i2c_clk_cfg_check.sv
module i2c_clk_cfg_check #(
  parameter int FREQ_W       = 6,
  parameter int STD_MIN_MHZ  = 2,
  parameter int FAST_MIN_MHZ = 4
) (
  input  logic              fast_mode,
  input  logic [FREQ_W-1:0] freq_mhz,
  output logic              bad
);

  localparam logic [FREQ_W-1:0] STD_LIM  = FREQ_W'(STD_MIN_MHZ);
  localparam logic [FREQ_W-1:0] FAST_LIM = FREQ_W'(FAST_MIN_MHZ);

  assign bad = fast_mode ? (freq_mhz < FAST_LIM) : (freq_mhz < STD_LIM);

endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq
  import i2c_start_pkg::*;
#(
  parameter int FREQ_W       = 6,
  parameter int DIV_W        = 12,
  parameter int BYTE_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int STD_MIN_MHZ  = 2,
  parameter int FAST_MIN_MHZ = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periph_en,
  input  logic              fast_mode,
  input  logic [FREQ_W-1:0] freq_mhz,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              evt_ie,
  input  logic              sr1_rd,
  input  logic              dr_valid,
  output logic              dr_ready,
  input  logic [BYTE_W-1:0] dr_data,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              master,
  output logic              sb,
  output logic              evt_irq,
  output logic              ack_ok,
  output logic              cfg_bad
);

  localparam int                CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0]  ACK_SLOT = CNT_W'(BYTE_W);

  ms_state_e st_q, st_d;

  logic              tmr_done;
  logic              tmr_restart;
  logic              sda_s;
  logic              busy_w;
  logic              cfg_bad_w;
  logic              issue_ok;
  logic              dr_fire;
  logic              bit_end;
  logic              start_pend_q;
  logic              stop_pend_q;
  logic              sb_q;
  logic              armed_q;
  logic              master_q;
  logic              ack_q;
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  bit_q;

  i2c_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .sda_s (sda_s),
    .busy  (busy_w)
  );

  i2c_phase_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .period  (half_period),
    .done    (tmr_done)
  );

  i2c_clk_cfg_check #(
    .FREQ_W       (FREQ_W),
    .STD_MIN_MHZ  (STD_MIN_MHZ),
    .FAST_MIN_MHZ (FAST_MIN_MHZ)
  ) u_cfg (
    .fast_mode (fast_mode),
    .freq_mhz  (freq_mhz),
    .bad       (cfg_bad_w)
  );

  assign issue_ok = periph_en && !cfg_bad_w;
  assign dr_ready = (st_q == MS_HOLD) && sb_q && armed_q;
  assign dr_fire  = dr_valid && dr_ready;
  assign bit_end  = (st_q == MS_BIT_HI) && tmr_done;

  always_comb begin
    st_d = st_q;
    case (st_q)
      MS_IDLE:     if (start_pend_q && issue_ok && !busy_w) st_d = MS_ST_SDA;
      MS_ST_SDA:   if (tmr_done) st_d = MS_ST_SCL;
      MS_ST_SCL:   if (tmr_done) st_d = MS_HOLD;
      MS_HOLD:     if (dr_fire)  st_d = MS_BIT_LO;
      MS_BIT_LO:   if (tmr_done) st_d = MS_BIT_HI;
      MS_BIT_HI:   if (tmr_done) st_d = (bit_q == ACK_SLOT) ? MS_BYTE_END : MS_BIT_LO;
      MS_BYTE_END: begin
        if (start_pend_q)     st_d = MS_RS_SDA;
        else if (stop_pend_q) st_d = MS_SP_SDA;
      end
      MS_RS_SDA:   if (tmr_done) st_d = MS_RS_SCL;
      MS_RS_SCL:   if (tmr_done) st_d = MS_ST_SDA;
      MS_SP_SDA:   if (tmr_done) st_d = MS_SP_SCL;
      MS_SP_SCL:   if (tmr_done) st_d = MS_SP_REL;
      MS_SP_REL:   if (tmr_done) st_d = MS_IDLE;
      default:     st_d = MS_IDLE;
    endcase
  end

  // every state change opens a fresh half-period window
  assign tmr_restart = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= MS_IDLE;
      start_pend_q <= 1'b0;
      stop_pend_q  <= 1'b0;
      master_q     <= 1'b0;
      sb_q         <= 1'b0;
      armed_q      <= 1'b0;
      ack_q        <= 1'b0;
      sh_q         <= '0;
      bit_q        <= '0;
    end else begin
      st_q <= st_d;

      if (st_d == MS_ST_SDA && st_q != MS_ST_SDA) start_pend_q <= 1'b0;
      else if (start_req && issue_ok)             start_pend_q <= 1'b1;

      if (st_d == MS_SP_SDA && st_q != MS_SP_SDA) stop_pend_q <= 1'b0;
      else if (stop_req && master_q)              stop_pend_q <= 1'b1;

      if (st_q == MS_IDLE && st_d == MS_ST_SDA)        master_q <= 1'b1;
      else if (st_q == MS_SP_REL && st_d == MS_IDLE)   master_q <= 1'b0;

      if (st_q == MS_ST_SCL && st_d == MS_HOLD) sb_q <= 1'b1;
      else if (dr_fire)                         sb_q <= 1'b0;

      // status read arms, data write consumes
      if (dr_fire || !sb_q) armed_q <= 1'b0;
      else if (sr1_rd)      armed_q <= 1'b1;

      if (dr_fire) begin
        sh_q  <= dr_data;
        bit_q <= '0;
        ack_q <= 1'b0;
      end else if (bit_end) begin
        if (bit_q == ACK_SLOT) begin
          ack_q <= !sda_s;
        end else begin
          sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st_q)
      MS_ST_SDA:   sda_oe = 1'b1;
      MS_ST_SCL,
      MS_HOLD:     begin scl_oe = 1'b1; sda_oe = 1'b1; end
      MS_BIT_LO:   begin scl_oe = 1'b1; sda_oe = (bit_q != ACK_SLOT) && !sh_q[BYTE_W-1]; end
      MS_BIT_HI:   sda_oe = (bit_q != ACK_SLOT) && !sh_q[BYTE_W-1];
      MS_BYTE_END,
      MS_RS_SDA:   scl_oe = 1'b1;
      MS_SP_SDA:   begin scl_oe = 1'b1; sda_oe = 1'b1; end
      MS_SP_SCL:   sda_oe = 1'b1;
      default:     ;
    endcase
  end

  assign busy    = busy_w;
  assign master  = master_q;
  assign sb      = sb_q;
  assign evt_irq = sb_q && evt_ie;
  assign ack_ok  = ack_q;
  assign cfg_bad = cfg_bad_w;

endmodule

// File: rtl/i2c_start_seq_chk.sv
module i2c_start_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic periph_en,
  input logic cfg_bad,
  input logic busy,
  input logic master,
  input logic sb,
  input logic dr_valid,
  input logic dr_ready
);

  AST_START_ON_FREE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master) |-> !$past(busy)); // R2

  AST_START_NEEDS_VALID_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master) |-> $past(periph_en && !cfg_bad)); // R10

  AST_SB_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sb) |-> $past(dr_valid && dr_ready)); // R5

  AST_SB_ONLY_AS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb) |-> master); // R4

  AST_SB_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sb |-> busy); // R3

  AST_RELEASE_WITHOUT_SB: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(master) |-> !sb); // R9

endmodule

bind i2c_start_seq i2c_start_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .periph_en (periph_en),
  .cfg_bad   (cfg_bad),
  .busy      (busy),
  .master    (master),
  .sb        (sb),
  .dr_valid  (dr_valid),
  .dr_ready  (dr_ready)
);

// File: tb/i2c_start_seq_bench.sv
module i2c_start_seq_bench;

  localparam int         HP       = 4;
  localparam logic [6:0] SLV_ADDR = 7'h52;
  localparam int         NVEC     = 6;
  // {fast_mode, freq_mhz[5:0], expected cfg_bad}
  localparam logic [7:0] CFG_VEC [NVEC] = '{
    {1'b0, 6'd1,  1'b1},
    {1'b0, 6'd2,  1'b0},
    {1'b1, 6'd3,  1'b1},
    {1'b1, 6'd4,  1'b0},
    {1'b0, 6'd0,  1'b1},
    {1'b1, 6'd63, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       periph_en = 1'b0;
  logic       fast_mode = 1'b0;
  logic [5:0] freq_mhz = 6'd8;
  logic [11:0] half_period = 12'(HP);
  logic       start_req = 1'b0;
  logic       stop_req = 1'b0;
  logic       evt_ie = 1'b0;
  logic       sr1_rd = 1'b0;
  logic       dr_valid = 1'b0;
  logic [7:0] dr_data = 8'h00;
  logic       dr_ready, scl_oe, sda_oe, busy, master, sb, evt_irq, ack_ok, cfg_bad;
  logic       ext_scl_oe = 1'b0;
  logic       ext_sda_oe = 1'b0;
  logic       s_ack = 1'b0;
  logic       scl_line, sda_line;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  assign scl_line = !(scl_oe || ext_scl_oe);
  assign sda_line = !(sda_oe || ext_sda_oe || s_ack);

  always #5 clk = !clk;

  i2c_start_seq u_i2c_start_seq (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .fast_mode(fast_mode),
    .freq_mhz(freq_mhz), .half_period(half_period), .start_req(start_req),
    .stop_req(stop_req), .evt_ie(evt_ie), .sr1_rd(sr1_rd), .dr_valid(dr_valid),
    .dr_ready(dr_ready), .dr_data(dr_data), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .master(master), .sb(sb),
    .evt_irq(evt_irq), .ack_ok(ack_ok), .cfg_bad(cfg_bad)
  );

  // slave model and bus observer
  logic       s_scl = 1'b1;
  logic       s_sda = 1'b1;
  logic [3:0] s_cnt = 4'hF;
  logic [7:0] s_rx = 8'h00;
  int         start_cnt = 0;
  int         stop_cnt = 0;
  int         run = 0;
  int         hi_len = 0;
  int         lo_len = 0;

  always @(posedge clk) begin
    s_scl <= scl_line;
    s_sda <= sda_line;
    if (scl_line != s_scl) begin
      if (s_scl) hi_len <= run;
      else       lo_len <= run;
      run <= 1;
    end else begin
      run <= run + 1;
    end
    if (s_scl && scl_line && s_sda && !sda_line) begin
      s_cnt <= 4'd0;
      start_cnt <= start_cnt + 1;
    end else if (s_scl && scl_line && !s_sda && sda_line) begin
      s_cnt <= 4'hF;
      stop_cnt <= stop_cnt + 1;
    end else if (!s_scl && scl_line && s_cnt < 4'd8) begin
      s_rx  <= {s_rx[6:0], sda_line};
      s_cnt <= s_cnt + 1'b1;
    end else if (s_scl && !scl_line) begin
      if (s_ack) begin
        s_ack <= 1'b0;
      end else if (s_cnt == 4'd8) begin
        s_ack <= (s_rx[7:1] == SLV_ADDR);
        s_cnt <= 4'd9;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
  endtask

  task automatic read_then_write(input logic [7:0] b);
    sr1_rd = 1'b1; @(negedge clk); sr1_rd = 1'b0;
    dr_valid = 1'b1; dr_data = b;
    @(negedge clk);
    dr_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int n;
    int sc;
    tick(3);
    chk("R1 scl_oe in reset", int'(scl_oe), 0);
    chk("R1 sda_oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(2);
    chk("R1 flags after reset", int'({sb, master, busy}), 0);

    // R10: frequency check table
    for (int v = 0; v < NVEC; v++) begin
      fast_mode = CFG_VEC[v][7];
      freq_mhz  = CFG_VEC[v][6:1];
      @(negedge clk);
      chk("R10 cfg_bad vector", int'(cfg_bad), int'(CFG_VEC[v][0]));
    end

    // R10: start ignored while disabled or misconfigured
    fast_mode = 1'b0; freq_mhz = 6'd8; periph_en = 1'b0;
    pulse_start(); tick(20);
    chk("R10 disabled start ignored", int'({master, sda_oe}), 0);
    periph_en = 1'b1; fast_mode = 1'b1; freq_mhz = 6'd3;
    pulse_start(); tick(20);
    chk("R10 bad cfg start ignored", int'({master, sda_oe}), 0);
    freq_mhz = 6'd8; tick(20);
    chk("R10 dropped request stays dropped", int'(master), 0);

    // R3/R2: another master owns the bus
    ext_sda_oe = 1'b1; tick(5);
    chk("R3 busy on external start", int'(busy), 1);
    pulse_start(); tick(30);
    chk("R2 no start while busy", int'({master, sda_oe}), 0);
    ext_sda_oe = 1'b0;
    n = 0;
    while (busy && n < 20) begin @(negedge clk); n++; end
    chk("R3 busy cleared by stop", int'(busy), 0);
    n = 0;
    while (!master && n < 20) begin @(negedge clk); n++; end
    chk("R2 start issued once free", int'(master), 1);

    // R4: start timing
    chk("R4 scl high at start", int'(scl_line), 1);
    n = 0;
    while (scl_line && !sda_line && n < 50) begin n++; @(negedge clk); end
    chk("R4 sda-low hold cycles", n, HP);
    n = 0;
    while (!sb && n < 50) begin n++; @(negedge clk); end
    chk("R4 scl-low cycles before sb", n, HP);
    chk("R4 sb and master", int'({sb, master}), 3);

    // R6
    chk("R6 irq masked", int'(evt_irq), 0);
    evt_ie = 1'b1; @(negedge clk);
    chk("R6 irq enabled", int'(evt_irq), 1);

    // R5: write without read is held off
    dr_valid = 1'b1; dr_data = {SLV_ADDR, 1'b0};
    tick(10);
    chk("R5 write before read not taken", int'({sb, dr_ready}), 2);
    sr1_rd = 1'b1; @(negedge clk); sr1_rd = 1'b0;
    chk("R5 ready after status read", int'(dr_ready), 1);
    @(negedge clk);
    dr_valid = 1'b0;
    chk("R5 sb cleared by write", int'({sb, evt_irq}), 0);

    // R7/R11: address byte with acknowledge
    n = 0;
    while (s_cnt != 4'd9 && n < 400) begin @(negedge clk); n++; end
    n = 0;
    while (s_ack && n < 100) begin @(negedge clk); n++; end
    tick(2);
    chk("R7 byte on the wire", int'(s_rx), int'({SLV_ADDR, 1'b0}));
    chk("R7 ack sampled", int'(ack_ok), 1);
    chk("R11 scl high phase", hi_len, HP);
    chk("R11 scl low phase", lo_len, HP);
    tick(20);
    chk("R7 clock held low after byte", int'({scl_oe, sda_oe, master}), 5);

    // R5: a read while sb is clear does not arm
    sr1_rd = 1'b1; @(negedge clk); sr1_rd = 1'b0;
    // R8: repeated start from the held state
    sc = start_cnt;
    pulse_start();
    n = 0;
    while (!sb && n < 200) begin @(negedge clk); n++; end
    chk("R8 repeated start seen", start_cnt, sc + 1);
    chk("R5 not armed by early read", int'(dr_ready), 0);

    // R8: request during a byte is deferred
    read_then_write(8'h3C);
    n = 0;
    while (s_cnt != 4'd3 && n < 400) begin @(negedge clk); n++; end
    sc = start_cnt;
    start_req = 1'b1; stop_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0; stop_req = 1'b0;
    n = 0;
    while (s_cnt != 4'd8 && n < 400) begin @(negedge clk); n++; end
    chk("R8 no start mid-byte", start_cnt, sc);
    n = 0;
    while (!sb && n < 400) begin @(negedge clk); n++; end
    chk("R8 restart after byte", start_cnt, sc + 1);
    chk("R8 full byte sent first", int'(s_rx), 'h3C);
    chk("R7 nack sampled", int'(ack_ok), 0);
    chk("R9 start served before stop", int'(master), 1);

    // R9: pending stop after the next byte
    sc = stop_cnt;
    read_then_write({SLV_ADDR, 1'b1});
    n = 0;
    while (master && n < 600) begin @(negedge clk); n++; end
    chk("R9 master released", int'(master), 0);
    chk("R9 stop on the wire", stop_cnt, sc + 1);
    chk("R7 read address acked", int'(ack_ok), 1);
    tick(5);
    chk("R9 lines released, bus free", int'({scl_oe, sda_oe, busy}), 0);

    // R9: stop while idle is ignored
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    tick(30);
    chk("R9 idle stop ignored", int'({master, scl_oe, sda_oe}), 0);
    chk("R9 no extra stop", stop_cnt, sc + 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule